// File: doc/BRIEF.md
# Open-Drain Line Direction Relay

This block joins pairs of open-drain lines that both rest high: a host-facing line and a card-facing line. For each pair it watches the sampled levels of both wires. The side that goes low first is the master. After a fixed delay the block pulls the other side, the slave, low. When the master lets go, the block stops pulling the slave and fires a short active pull-up boost on that side. It then waits until both wires read high before it accepts a new low.

A session controller gates the card side through a single enable. While the enable is low, every card-side line is pulled low and host activity is ignored. The same top module carries a parameterised number of independent lanes: one data line and two auxiliary lines by default. It only produces drive-low and boost enables. Pull-up resistors, level shifting and edge shaping stay outside the block.

Top module: `io_line_relay`

## Requirements
- R1: After reset with `line_en` low, every lane has `card_pull`=1 and `host_pull`, `host_boost`, `card_boost`=0. While `line_en` stays low, a low on a host line changes none of these outputs.
- R2: With `line_en` high and both lines of a lane high, the lane asserts none of its four outputs, and no output changes without line activity.
- R3: When a host line falls first, that lane's `card_pull` goes to 1 at clock edge DELAY_CYC+3, where edge 1 is the first rising edge after the line goes low (two synchroniser stages, one detect stage). `host_pull` stays 0.
- R4: When a card line falls first, that lane's `host_pull` goes to 1 at edge DELAY_CYC+3, counted the same way. `card_pull` stays 0.
- R5: While a lane's slave side is being pulled, a low put on that slave line by the far end neither changes the lane's direction nor asserts the master side's pull.
- R6: When the master line returns high, the slave pull drops at edge 3 after the release. At that same edge the slave-side boost rises, and it stays high for exactly DELAY_CYC cycles.
- R7: If the master line returns high before the delay has run out, no pull is asserted on either side.
- R8: If both lines of a lane are first seen low in the same sample, the host side is the master. The card side receives the pull.
- R9: If the slave line is still low when the boost ends, the lane drives nothing and takes no new master. Once both lines are high, it returns to idle and handles the next transfer with normal timing.
- R10: A low on `line_en` ends any session at the next edge: `card_pull`=1, and `host_pull` and both boosts are 0 on all lanes. A high on `line_en` releases `card_pull` at the next edge.
- R11: Lanes are independent. Activity on one lane changes no output of another lane, including when two lanes transfer at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_en | input | 1 | Session enable; low forces card sides low |
| host_in | input | LANES | Level read from each host-side line |
| card_in | input | LANES | Level read from each card-side line |
| host_pull | output | LANES | 1 = pull host line low |
| card_pull | output | LANES | 1 = pull card line low |
| host_boost | output | LANES | 1 = active pull-up boost on host line |
| card_boost | output | LANES | 1 = active pull-up boost on card line |

## Verification
The case hardest to reach from the ports is contention: the far end keeps the slave line low after the master has released, so the boost ends while one wire is still low. The lane must then neither drive nor latch. The bench models each wire as a wired-AND of an external driver and the block's own pull. It holds the card driver low through the host's release and then releases it many cycles later. Double falls on one lane and concurrent transfers on two lanes are produced by changing both external drivers on the same falling clock edge.

// File: rtl/io_relay_pkg.sv
package io_relay_pkg;

   // Phase of one lane; the master side is kept separately.
   typedef enum logic [2:0] {
      PH_HOLD    = 3'd0,   // session disabled, card side held low
      PH_RECOVER = 3'd1,   // wait until both lines read high
      PH_IDLE    = 3'd2,   // armed for a falling edge on either side
      PH_WAIT    = 3'd3,   // master low, delay running
      PH_DRIVE   = 3'd4,   // slave pulled low
      PH_BOOST   = 3'd5    // slave released, boost pulse running
   } lane_phase_e;

   function automatic int unsigned cnt_bits(input int unsigned limit);
      return (limit < 2) ? 1 : $clog2(limit + 1);
   endfunction

endpackage

// File: rtl/relay_sync.sv
module relay_sync #(
   parameter int   WIDTH   = 1,
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("relay_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg_q[s] <= {WIDTH{RST_VAL}};
      end else begin
         stg_q[0] <= d;
         for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      end
   end

   assign q = stg_q[STAGES-1];

endmodule

// File: rtl/relay_timer.sv
module relay_timer #(
   parameter int DELAY_CYC = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic run,
   output logic done
);

   localparam int CW = io_relay_pkg::cnt_bits(DELAY_CYC);
   localparam logic [CW-1:0] LOAD_VAL = CW'(DELAY_CYC - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt_q <= '0;
      else if (load)               cnt_q <= LOAD_VAL;
      else if (run && cnt_q != 0)  cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);

endmodule

// File: rtl/relay_lane.sv
module relay_lane
   import io_relay_pkg::*;
#(
   parameter int DELAY_CYC = 10,
   parameter bit HOST_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_en,
   input  logic host_lvl,
   input  logic card_lvl,
   output logic host_pull,
   output logic card_pull,
   output logic host_boost,
   output logic card_boost
);

   lane_phase_e ph_q, ph_d;
   logic        card_mst_q, card_mst_d;
   logic        host_prev_q, card_prev_q;
   logic        host_fall, card_fall;
   logic        master_lvl;
   logic        tmr_load, tmr_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         host_prev_q <= 1'b1;
         card_prev_q <= 1'b1;
      end else begin
         host_prev_q <= host_lvl;
         card_prev_q <= card_lvl;
      end
   end

   assign host_fall  = host_prev_q & ~host_lvl;
   assign card_fall  = card_prev_q & ~card_lvl;
   assign master_lvl = card_mst_q ? card_lvl : host_lvl;

   // Tie-break for a same-sample double fall.
   logic card_takes;
   if (HOST_WINS) begin : g_host_pri
      assign card_takes = card_fall & ~host_fall;
   end else begin : g_card_pri
      assign card_takes = card_fall;
   end

   always_comb begin
      ph_d       = ph_q;
      card_mst_d = card_mst_q;
      tmr_load   = 1'b0;
      if (!line_en) begin
         ph_d = PH_HOLD;
      end else begin
         unique case (ph_q)
            PH_HOLD:    ph_d = PH_RECOVER;
            PH_RECOVER: if (host_lvl && card_lvl) ph_d = PH_IDLE;
            PH_IDLE: begin
               if (host_fall || card_fall) begin
                  ph_d       = PH_WAIT;
                  card_mst_d = card_takes;
                  tmr_load   = 1'b1;
               end
            end
            PH_WAIT: begin
               if (master_lvl)    ph_d = PH_RECOVER;
               else if (tmr_done) ph_d = PH_DRIVE;
            end
            PH_DRIVE: begin
               if (master_lvl) begin
                  ph_d     = PH_BOOST;
                  tmr_load = 1'b1;
               end
            end
            PH_BOOST:   if (tmr_done) ph_d = PH_RECOVER;
            default:    ph_d = PH_RECOVER;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q       <= PH_HOLD;
         card_mst_q <= 1'b0;
      end else begin
         ph_q       <= ph_d;
         card_mst_q <= card_mst_d;
      end
   end

   relay_timer #(.DELAY_CYC(DELAY_CYC)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (tmr_load),
      .run   (ph_q == PH_WAIT || ph_q == PH_BOOST),
      .done  (tmr_done)
   );

   logic in_drive, in_boost;
   assign in_drive   = (ph_q == PH_DRIVE);
   assign in_boost   = (ph_q == PH_BOOST);
   assign card_pull  = (ph_q == PH_HOLD) | (in_drive & ~card_mst_q);
   assign host_pull  = in_drive & card_mst_q;
   assign card_boost = in_boost & ~card_mst_q;
   assign host_boost = in_boost & card_mst_q;

endmodule

// File: rtl/io_line_relay.sv
module io_line_relay #(
   parameter int LANES       = 3,
   parameter int DELAY_CYC   = 10,
   parameter int SYNC_STAGES = 2,
   parameter bit HOST_WINS   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_en,
   input  logic [LANES-1:0] host_in,
   input  logic [LANES-1:0] card_in,
   output logic [LANES-1:0] host_pull,
   output logic [LANES-1:0] card_pull,
   output logic [LANES-1:0] host_boost,
   output logic [LANES-1:0] card_boost
);

   if (LANES < 1) begin : g_bad_lanes
      $error("io_line_relay: LANES must be at least 1");
   end
   if (DELAY_CYC < 4 || DELAY_CYC > 250) begin : g_bad_delay
      $error("io_line_relay: DELAY_CYC must lie in 4..250");
   end

   logic [LANES-1:0] host_s, card_s;

   relay_sync #(.WIDTH(LANES), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_host (
      .clk(clk), .rst_n(rst_n), .d(host_in), .q(host_s)
   );
   relay_sync #(.WIDTH(LANES), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_card (
      .clk(clk), .rst_n(rst_n), .d(card_in), .q(card_s)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      relay_lane #(.DELAY_CYC(DELAY_CYC), .HOST_WINS(HOST_WINS)) u_lane (
         .clk        (clk),
         .rst_n      (rst_n),
         .line_en    (line_en),
         .host_lvl   (host_s[l]),
         .card_lvl   (card_s[l]),
         .host_pull  (host_pull[l]),
         .card_pull  (card_pull[l]),
         .host_boost (host_boost[l]),
         .card_boost (card_boost[l])
      );
   end

endmodule

// File: rtl/io_line_relay_chk.sv
module io_line_relay_chk #(
   parameter int LANES     = 3,
   parameter int DELAY_CYC = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             line_en,
   input logic [LANES-1:0] host_in,
   input logic [LANES-1:0] card_in,
   input logic [LANES-1:0] host_pull,
   input logic [LANES-1:0] card_pull,
   input logic [LANES-1:0] host_boost,
   input logic [LANES-1:0] card_boost
);

   for (genvar l = 0; l < LANES; l++) begin : g_chk
      logic [7:0] blen_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                           blen_q <= '0;
         else if (host_boost[l] | card_boost[l]) blen_q <= blen_q + 1'b1;
         else                                  blen_q <= '0;
      end

      p_one_side_r3: assert property (@(posedge clk) disable iff (!rst_n)
         !(host_pull[l] && card_pull[l]));

      p_boost_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
         !(card_boost[l] && card_pull[l]) && !(host_boost[l] && host_pull[l])
         && !(host_boost[l] && card_boost[l]));

      p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
         !line_en |=> (card_pull[l] && !host_pull[l] && !host_boost[l] && !card_boost[l]));

      p_boost_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(card_boost[l]) |-> $past(card_pull[l]));

      p_boost_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (host_boost[l] || card_boost[l]) |-> (blen_q < 8'(DELAY_CYC)));

      p_card_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
         ($rose(card_pull[l]) && $past(line_en)) |-> !$past(host_in[l], 3));

      p_host_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(host_pull[l]) |-> !$past(card_in[l], 3));
   end

endmodule

bind io_line_relay io_line_relay_chk #(.LANES(LANES), .DELAY_CYC(DELAY_CYC)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .line_en    (line_en),
   .host_in    (host_in),
   .card_in    (card_in),
   .host_pull  (host_pull),
   .card_pull  (card_pull),
   .host_boost (host_boost),
   .card_boost (card_boost)
);

// File: tb/io_line_relay_tb.sv
module io_line_relay_tb;

   localparam int LANES = 3;
   localparam int D     = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic line_en = 1'b0;
   logic [LANES-1:0] host_ext = '1, card_ext = '1;
   logic [LANES-1:0] host_in, card_in, host_pull, card_pull, host_boost, card_boost;

   always #10 clk = ~clk;

   // wired-AND line model
   assign host_in = host_ext & ~host_pull;
   assign card_in = card_ext & ~card_pull;

   io_line_relay #(.LANES(LANES), .DELAY_CYC(D)) u_dut (
      .clk(clk), .rst_n(rst_n), .line_en(line_en),
      .host_in(host_in), .card_in(card_in),
      .host_pull(host_pull), .card_pull(card_pull),
      .host_boost(host_boost), .card_boost(card_boost)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_chk = 0;
   int n_err = 0;

   typedef struct {
      int    cyc;
      int    bitn;
      logic  val;
      string tag;
   } exp_t;
   exp_t exp_q[$];

   // bit layout per lane: 0 host_pull, 1 card_pull, 2 host_boost, 3 card_boost
   logic [4*LANES-1:0] obs, obs_prev;
   always_comb begin
      for (int l = 0; l < LANES; l++) begin
         obs[4*l]   = host_pull[l];
         obs[4*l+1] = card_pull[l];
         obs[4*l+2] = host_boost[l];
         obs[4*l+3] = card_boost[l];
      end
   end

   function automatic void push(int c, int b, logic v, string t);
      exp_t e;
      e.cyc = c; e.bitn = b; e.val = v; e.tag = t;
      exp_q.push_back(e);
   endfunction

   task automatic check(string tag, logic ok, string detail);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: %s", tag, detail);
      end
   endtask

   logic mon_on = 1'b0;
   always @(negedge clk) begin
      if (mon_on) begin
         for (int b = 0; b < 4*LANES; b++) begin
            if (obs[b] !== obs_prev[b]) begin
               if (exp_q.size() == 0) begin
                  check("R2/R11", 1'b0, $sformatf("unexpected change bit %0d to %b at cycle %0d, expected none",
                        b, obs[b], cyc));
               end else begin
                  exp_t e;
                  e = exp_q.pop_front();
                  check(e.tag, (e.cyc == cyc) && (e.bitn == b) && (e.val === obs[b]),
                        $sformatf("actual bit %0d=%b at cycle %0d, expected bit %0d=%b at cycle %0d",
                                  b, obs[b], cyc, e.bitn, e.val, e.cyc));
               end
            end
         end
         obs_prev = obs;
      end
   end

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   // host-initiated transfer on one lane
   task automatic host_txn(int l, int low_len, string tag);
      int c;
      @(negedge clk);
      host_ext[l] = 1'b0; c = cyc;
      push(c + 3 + D, 4*l+1, 1'b1, tag);
      idle(low_len);
      host_ext[l] = 1'b1; c = cyc;
      push(c + 3, 4*l+1, 1'b0, "R6");
      push(c + 3, 4*l+3, 1'b1, "R6");
      push(c + 3 + D, 4*l+3, 1'b0, "R6");
      idle(2*D + 10);
   endtask

   // card-initiated transfer on one lane
   task automatic card_txn(int l, int low_len, string tag);
      int c;
      @(negedge clk);
      card_ext[l] = 1'b0; c = cyc;
      push(c + 3 + D, 4*l, 1'b1, tag);
      idle(low_len);
      card_ext[l] = 1'b1; c = cyc;
      push(c + 3, 4*l, 1'b0, "R6");
      push(c + 3, 4*l+2, 1'b1, "R6");
      push(c + 3 + D, 4*l+2, 1'b0, "R6");
      idle(2*D + 10);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: run did not complete, actual hung, expected finish");
      finish_run();
   end

   initial begin
      int c;
      idle(5);
      // R1: reset state
      check("R1", card_pull === 3'b111, $sformatf("card_pull=%b expected 111", card_pull));
      check("R1", host_pull === 3'b000 && host_boost === 3'b000 && card_boost === 3'b000,
            $sformatf("host_pull=%b boosts=%b/%b expected 0", host_pull, host_boost, card_boost));
      rst_n = 1'b1;
      idle(3);
      obs_prev = obs;
      mon_on = 1'b1;
      // R1: host low ignored while disabled
      host_ext[0] = 1'b0;
      idle(D + 8);
      host_ext[0] = 1'b1;
      idle(4);
      check("R1", card_pull === 3'b111 && host_pull === 3'b000,
            $sformatf("card_pull=%b host_pull=%b expected 111/000", card_pull, host_pull));

      // R10: enabling releases card lines next edge
      @(negedge clk);
      line_en = 1'b1; c = cyc;
      for (int l = 0; l < LANES; l++) push(c + 1, 4*l+1, 1'b0, "R10");
      idle(10);
      check("R2", obs === '0, $sformatf("outputs=%b expected all 0", obs));

      host_txn(0, 30, "R3");
      card_txn(1, 25, "R4");
      host_txn(2, 60, "R3");

      // R7: short master pulse transfers nothing
      @(negedge clk);
      host_ext[1] = 1'b0;
      idle(3);
      host_ext[1] = 1'b1;
      idle(D + 10);
      check("R7", card_pull[1] === 1'b0, $sformatf("card_pull[1]=%b expected 0", card_pull[1]));

      // R8: same-sample double fall on lane 2, host wins
      @(negedge clk);
      host_ext[2] = 1'b0; card_ext[2] = 1'b0; c = cyc;
      push(c + 3 + D, 9, 1'b1, "R8");
      idle(D + 20);
      check("R8", host_pull[2] === 1'b0, $sformatf("host_pull[2]=%b expected 0", host_pull[2]));
      host_ext[2] = 1'b1; card_ext[2] = 1'b1; c = cyc;
      push(c + 3, 9, 1'b0, "R8");
      push(c + 3, 11, 1'b1, "R6");
      push(c + 3 + D, 11, 1'b0, "R6");
      idle(2*D + 10);

      // R5/R9: contention, far end holds card line low past the boost
      @(negedge clk);
      host_ext[0] = 1'b0; c = cyc;
      push(c + 3 + D, 1, 1'b1, "R3");
      idle(D + 8);
      card_ext[0] = 1'b0;
      idle(10);
      check("R5", host_pull[0] === 1'b0, $sformatf("host_pull[0]=%b expected 0", host_pull[0]));
      host_ext[0] = 1'b1; c = cyc;
      push(c + 3, 1, 1'b0, "R6");
      push(c + 3, 3, 1'b1, "R6");
      push(c + 3 + D, 3, 1'b0, "R6");
      idle(D + 40);
      check("R9", host_pull[0] === 1'b0 && card_pull[0] === 1'b0,
            $sformatf("pulls=%b/%b expected 0/0", host_pull[0], card_pull[0]));
      card_ext[0] = 1'b1;
      idle(10);
      host_txn(0, 20, "R9");

      // R11: two lanes at once
      @(negedge clk);
      host_ext[0] = 1'b0; card_ext[2] = 1'b0; c = cyc;
      push(c + 3 + D, 1, 1'b1, "R11");
      push(c + 3 + D, 8, 1'b1, "R11");
      idle(D + 15);
      host_ext[0] = 1'b1; card_ext[2] = 1'b1; c = cyc;
      push(c + 3, 1, 1'b0, "R11");
      push(c + 3, 3, 1'b1, "R11");
      push(c + 3, 8, 1'b0, "R11");
      push(c + 3, 10, 1'b1, "R11");
      push(c + 3 + D, 3, 1'b0, "R11");
      push(c + 3 + D, 10, 1'b0, "R11");
      idle(2*D + 10);

      // R10: disable in the middle of a card-mastered transfer
      @(negedge clk);
      card_ext[1] = 1'b0; c = cyc;
      push(c + 3 + D, 4, 1'b1, "R4");
      idle(D + 8);
      line_en = 1'b0; c = cyc;
      push(c + 1, 1, 1'b1, "R10");
      push(c + 1, 4, 1'b0, "R10");
      push(c + 1, 5, 1'b1, "R10");
      push(c + 1, 9, 1'b1, "R10");
      idle(5);
      card_ext[1] = 1'b1;
      host_ext[0] = 1'b0;
      idle(D + 8);
      host_ext[0] = 1'b1;
      idle(4);
      check("R1", card_pull === 3'b111 && host_pull === 3'b000,
            $sformatf("card_pull=%b host_pull=%b expected 111/000", card_pull, host_pull));
      @(negedge clk);
      line_en = 1'b1; c = cyc;
      for (int l = 0; l < LANES; l++) push(c + 1, 4*l+1, 1'b0, "R10");
      idle(10);
      card_txn(1, 15, "R10");

      check("R2", exp_q.size() == 0, $sformatf("%0d expected events pending, expected 0", exp_q.size()));
      check("R2", obs === '0, $sformatf("outputs=%b expected all 0", obs));
      finish_run();
   end

endmodule